// File: doc/BRIEF.md
# Host Interrupt Generation Register

This block is a pair of 32-bit register views that a processor uses to flag an interrupt toward an external host. Both views share one array of 28 source flags held in bits 31:4. The *raise* view sets flags: a 1 in a source bit sets that flag. The *acknowledge* view clears flags: a 1 in a source bit clears it. In both views a 0 leaves the flag unchanged. Both views read back the same value, which is the flag array with the low nibble forced to zero.

Bit 0 of the raise view is a trigger. A trigger fires one stretched pulse on `host_irq`. The pulse is timed on a slow clock-enable strobe (`slow_tick`). The output stays high for four strobe periods and then stays low for four more. A trigger that lands while a pulse is pending or while its eight-period window is still open is dropped. Triggers that arrive close together therefore produce a single pulse.

Top module: `host_irq_gen`

## Requirements
- R1: `rd_data[31:4]` always shows the 28 source flags. With no write, the flags keep their value.
- R2: A cycle with `raise_wr` high sets every flag whose bit in `wr_data[31:4]` is 1. Flags whose bit is 0 are unchanged.
- R3: A cycle with `ack_wr` high clears every flag whose bit in `wr_data[31:4]` is 1. Flags whose bit is 0 are unchanged.
- R4: If `raise_wr` and `ack_wr` are both high and the same flag bit is 1, the flag ends cleared.
- R5: `rd_data[3:0]` always reads 0. This covers the trigger bit 0 and reserved bits 3:1, whatever was written to them.
- R6: A raise write with `wr_data[0]`=1 is accepted when the block is idle (no pulse pending, no window open). The pulse starts at the first `slow_tick` edge after the write cycle. `host_irq` is then high for exactly 4 strobe periods (24 clocks at one strobe per 6 clocks) and low for 4 more.
- R7: A trigger while a pulse is pending or inside its 8-period window has no effect. A trigger after the window closes starts a new pulse.
- R8: Synchronous active-high `rst` clears all flags, cancels any pending or running pulse and drives `host_irq` low.
- R9: `host_irq` changes only at clock edges where `slow_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_wr | input | 1 | Write strobe for the set/trigger view |
| ack_wr | input | 1 | Write strobe for the clear view |
| wr_data | input | 32 | Write data shared by both views |
| slow_tick | input | 1 | One-cycle enable marking each slow-clock period |
| rd_data | output | 32 | Flag readback (same for both views) |
| host_irq | output | 1 | Stretched interrupt pulse to the host |

## Verification
Two pairs of events can land in the same cycle. The first is a set and a clear aimed at one flag. The second is a trigger and the edge at which the window closes (or at which a pending pulse starts). The bench fires both write strobes together with overlapping data and expects the overlapping bits to read 0 afterwards. It also issues triggers at several offsets into a running window. A cycle-level reference model predicts every `host_irq` and `rd_data` value, and pulse counts and the measured high width are compared against the single-pulse and double-pulse expectations.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int SRC_LSB = 4;
  localparam int SRC_N   = DATA_W - SRC_LSB;

  // Next flag state: clear has priority over set.
  function automatic logic [SRC_N-1:0] flags_next(
    input logic [SRC_N-1:0] cur,
    input logic             set_en,
    input logic             clr_en,
    input logic [SRC_N-1:0] mask
  );
    logic [SRC_N-1:0] set_v;
    logic [SRC_N-1:0] clr_v;
    set_v = set_en ? mask : '0;
    clr_v = clr_en ? mask : '0;
    return (cur | set_v) & ~clr_v;
  endfunction

  // Readback word: flags on top, zero nibble below.
  function automatic logic [DATA_W-1:0] read_word(input logic [SRC_N-1:0] f);
    return {f, {SRC_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/hirq_src_flags.sv
module hirq_src_flags
  import host_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [SRC_N-1:0] mask,
  output logic [SRC_N-1:0] flags
);
  logic [SRC_N-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_next(flags_q, set_en, clr_en, mask);
  end

  assign flags = flags_q;
endmodule

// File: rtl/hirq_pulse_timer.sv
module hirq_pulse_timer #(
  parameter int HI_TICKS = 4,
  parameter int LO_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic trig,
  output logic pulse,
  output logic accept,
  output logic start,
  output logic win_end
);
  localparam int WIN = HI_TICKS + LO_TICKS;
  localparam int CW  = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);
  localparam logic [CW-1:0] HI_C = CW'(HI_TICKS);

  logic          pend_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign accept  = trig & ~busy_q & ~pend_q;
  assign start   = tick & pend_q;
  assign win_end = tick & busy_q & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      pend_q <= 1'b0;
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      if (accept) pend_q <= 1'b1;
      if (tick && busy_q) begin
        if (win_end) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign pulse = busy_q & (cnt_q < HI_C);
endmodule

// File: rtl/host_irq_gen.sv
module host_irq_gen
  import host_irq_pkg::*;
#(
  parameter int HI_TICKS = 4,
  parameter int LO_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raise_wr,
  input  logic              ack_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              slow_tick,
  output logic [DATA_W-1:0] rd_data,
  output logic              host_irq
);
  logic [SRC_N-1:0] flags;
  logic             trig_req;
  logic             trig_accept;
  logic             pulse_start;
  logic             window_end;

  assign trig_req = raise_wr & wr_data[0];

  hirq_src_flags u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_en (raise_wr),
    .clr_en (ack_wr),
    .mask   (wr_data[DATA_W-1:SRC_LSB]),
    .flags  (flags)
  );

  hirq_pulse_timer #(
    .HI_TICKS (HI_TICKS),
    .LO_TICKS (LO_TICKS)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .tick    (slow_tick),
    .trig    (trig_req),
    .pulse   (host_irq),
    .accept  (trig_accept),
    .start   (pulse_start),
    .win_end (window_end)
  );

  assign rd_data = read_word(flags);
endmodule

// File: rtl/host_irq_gen_chk.sv
module host_irq_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        raise_wr,
  input logic        ack_wr,
  input logic [31:0] wr_data,
  input logic        slow_tick,
  input logic [31:0] rd_data,
  input logic        host_irq,
  input logic        pulse_start
);
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!raise_wr && !ack_wr) |=> $stable(rd_data));

  assert_set_R2: assert property (@(posedge clk) disable iff (rst)
    (raise_wr && !ack_wr) |=>
      ((rd_data[31:4] & $past(wr_data[31:4])) == $past(wr_data[31:4])));

  // also covers R4: clear beats a simultaneous set
  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    ack_wr |=> ((rd_data[31:4] & $past(wr_data[31:4])) == 28'd0));

  assert_low_nibble_R5: assert property (@(posedge clk) disable iff (rst)
    rd_data[3:0] == 4'd0);

  assert_start_high_R6: assert property (@(posedge clk) disable iff (rst)
    pulse_start |=> host_irq);

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (rd_data == 32'd0 && !host_irq));

  assert_tick_only_R9: assert property (@(posedge clk) disable iff (rst)
    !slow_tick |=> $stable(host_irq));
endmodule

bind host_irq_gen host_irq_gen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .raise_wr    (raise_wr),
  .ack_wr      (ack_wr),
  .wr_data     (wr_data),
  .slow_tick   (slow_tick),
  .rd_data     (rd_data),
  .host_irq    (host_irq),
  .pulse_start (pulse_start)
);

// File: tb/host_irq_gen_bench.sv
module host_irq_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        raise_wr = 1'b0;
  logic        ack_wr = 1'b0;
  logic [31:0] wr_data = 32'd0;
  logic        slow_tick = 1'b0;
  logic [31:0] rd_data;
  logic        host_irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  host_irq_gen u_host_irq_gen (
    .clk (clk), .rst (rst), .raise_wr (raise_wr), .ack_wr (ack_wr),
    .wr_data (wr_data), .slow_tick (slow_tick),
    .rd_data (rd_data), .host_irq (host_irq)
  );

  // strobe generator: one cycle high in every six
  int tick_ph = 0;
  always @(negedge clk) begin
    tick_ph   = (tick_ph == 5) ? 0 : tick_ph + 1;
    slow_tick <= (tick_ph == 5);
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: flags, pending, remaining window ticks
  typedef struct { logic irq; logic [31:0] rd; } exp_t;
  exp_t        sb_q[$];
  logic [27:0] m_flags = '0;
  bit          m_pend = 0;
  int          m_rem = 0;

  always @(posedge clk) begin
    bit   tr;
    exp_t e;
    tr = raise_wr && wr_data[0] && m_rem == 0 && !m_pend;
    if (rst) begin
      m_flags = '0; m_pend = 0; m_rem = 0;
    end else begin
      if (raise_wr) m_flags = m_flags | wr_data[31:4];
      if (ack_wr)   m_flags = m_flags & ~wr_data[31:4];
      if (slow_tick && m_pend) begin m_rem = 8; m_pend = 0; end
      else begin
        if (slow_tick && m_rem > 0) m_rem--;
        if (tr) m_pend = 1;
      end
    end
    e.irq = (m_rem > 4);
    e.rd  = {m_flags, 4'b0000};
    sb_q.push_back(e);
  end

  // monitor: compare every cycle, count pulses and width
  int  pulses = 0;
  int  hi_run = 0;
  int  last_width = 0;
  bit  prev_irq = 0;
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      check(host_irq === e.irq, "R6/R7/R9 scoreboard host_irq", host_irq, e.irq);
      check(rd_data === e.rd, "R1/R2/R3 scoreboard rd_data", rd_data, e.rd);
    end
    if (host_irq && !prev_irq) pulses++;
    if (host_irq) hi_run++;
    else if (prev_irq) begin last_width = hi_run; hi_run = 0; end
    prev_irq = host_irq;
  end

  task automatic write(input bit g, input bit a, input logic [31:0] d);
    @(negedge clk);
    raise_wr = g; ack_wr = a; wr_data = d;
    @(negedge clk);
    raise_wr = 0; ack_wr = 0; wr_data = 32'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    check(rd_data == 0 && !host_irq, "R8 reset state", {host_irq, rd_data}, 0);

    write(1, 0, 32'hA5A5_A5A0);
    idle(1);
    check(rd_data == 32'hA5A5_A5A0, "R2 set pattern", rd_data, 32'hA5A5_A5A0);
    write(1, 0, 32'h0000_0F00);
    idle(1);
    check(rd_data == 32'hA5A5_AFA0, "R2 zero bits keep", rd_data, 32'hA5A5_AFA0);
    idle(4);
    check(rd_data == 32'hA5A5_AFA0, "R1 hold", rd_data, 32'hA5A5_AFA0);

    write(0, 1, 32'h0505_0F00);
    idle(1);
    check(rd_data == 32'hA0A0_A0A0, "R3 clear", rd_data, 32'hA0A0_A0A0);

    write(1, 1, 32'hFF00_0010);
    idle(1);
    check(rd_data == 32'h00A0_A0A0, "R4 clear wins", rd_data, 32'h00A0_A0A0);

    write(1, 0, 32'h0000_000E);
    idle(1);
    check(rd_data[3:0] == 0, "R5 reserved nibble", rd_data[3:0], 0);
    idle(60);
    pulses = 0;
    write(1, 0, 32'h0000_0001);
    idle(1);
    check(rd_data[3:0] == 0, "R5 trigger reads 0", rd_data[3:0], 0);
    idle(80);
    check(pulses == 1, "R6 single pulse", pulses, 1);
    check(last_width == 24, "R6 high width", last_width, 24);

    pulses = 0;
    write(1, 0, 32'h1);
    idle(10);
    write(1, 0, 32'h1);
    idle(20);
    write(1, 0, 32'h1);
    idle(80);
    check(pulses == 1, "R7 triggers swallowed", pulses, 1);

    pulses = 0;
    write(1, 0, 32'h1);
    idle(70);
    write(1, 0, 32'h1);
    idle(80);
    check(pulses == 2, "R7 after window", pulses, 2);

    write(1, 0, 32'hFFFF_FFF1);
    idle(12);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check(rd_data == 0 && !host_irq, "R8 reset mid pulse", {host_irq, rd_data}, 0);
    idle(60);
    check(!host_irq, "R8 pulse cancelled", host_irq, 0);

    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule